// File: doc/BRIEF.md
# Counter-Flow Systolic Convolver

This block computes a one-dimensional convolution of a sample stream with a set of K coefficients on a linear array of K identical cells that use only neighbour-to-neighbour wiring. Samples enter at cell 0 and move one cell to the right on every clock. Coefficients enter at cell K-1 and move one cell to the left on every clock. Each cell holds one partial result in place. Whenever a valid sample and a valid coefficient sit in the same cell, the cell multiplies them and adds the product to that partial result. A finished result moves into a drain register and travels right, one cell per clock, along a separate shift chain. It leaves the block at the same end where the samples exit.

Both streams use a two-cycle cadence: one cycle carries a value and the next is a bubble. Because the two streams move in opposite directions, this spacing makes every sample meet every coefficient it needs. The caller repeats the coefficient set without end, in ascending order, and marks the first coefficient of each pass with a tag. A cell restarts its sum on a tagged coefficient. It sends out a result once it has gathered all K products of one window. A window with a missing sample is discarded.

Top module: `cf_convolver`

## Requirements
- R1: While rst_ni is low and after it rises, y_valid_o is low. It goes high only for a window whose K products have all been gathered.
- R2: Input contract. Sample slot s is offered at cycle t0+2s, with x_valid_i low in a slot that carries no sample. Coefficient stream position m is offered at cycle t0+K-1+2m and carries w_((m mod K)+1). w_first_i is high exactly when that coefficient is w_1, and only together with w_valid_i. Neither x_valid_i nor w_valid_i is high on two consecutive cycles.
- R3: The result for the window that starts at slot s equals the sum over k=1..K of w_k times x at slot s+k-1. Operands are signed two's complement DATA_W-bit values. A cell's sum changes only in a cycle where it holds both a sample and a coefficient, or when it is cleared.
- R4: Results leave the block in ascending order of window start slot.
- R5: A result appears for every window whose K slots all hold a valid sample, and for no other window. A stream of K-1 samples gives no result. A stream of exactly K samples gives one result.
- R6: Results leave through a drain chain toward the sample-exit end, one cell per cycle. A cell never loads a result into its drain register while a result from upstream arrives there. Two results never leave on adjacent cycles. With an unbroken sample stream, results leave exactly two cycles apart.
- R7: A cell gathers at most K products into one result.
- R8: The result width is 2*DATA_W + clog2(K) bits. All K products at the most negative operand value still give the exact sum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| x_valid_i | input | 1 | A sample is present this cycle |
| x_data_i | input | DATA_W | Signed sample |
| w_valid_i | input | 1 | A coefficient is present this cycle |
| w_first_i | input | 1 | The coefficient is w_1, the start of a pass |
| w_data_i | input | DATA_W | Signed coefficient |
| y_valid_o | output | 1 | A result is present this cycle |
| y_data_o | output | ACC_W | Signed convolution result |

## Verification
Some properties are checked by assertions on every cycle. These cover the two-cycle cadence of both input streams, the rule that the tag comes only with a valid coefficient, the bound of K on products per result, and the rule that a cell's sum stays put unless it holds a meeting pair. They also cover the freedom from collisions in the drain chain and the minimum spacing of two cycles between results. Other behaviours can only be shown by the bench scenarios, which compare the output stream against a reference convolution. These are the arithmetic value of each result, coefficient order (revealed by an impulse), the ascending order of results, the dropping of windows that contain a bubble slot, the boundaries at K-1 and K samples, the exact two-cycle exit rate, and full precision at extreme operand values.

// File: rtl/cfc_pkg.sv
package cfc_pkg;

  typedef enum logic [1:0] {
    CELL_IDLE,
    CELL_START,
    CELL_ADD,
    CELL_DROP
  } cell_act_e;

  function automatic int unsigned acc_width(int unsigned dw, int unsigned taps);
    return 2 * dw + $clog2(taps);
  endfunction

endpackage

// File: rtl/cfc_cell.sv
module cfc_cell
  import cfc_pkg::*;
#(
  parameter int unsigned NUM_TAPS = 4,
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned ACC_W    = 18
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              x_v_i,
  input  logic [DATA_W-1:0] x_d_i,
  output logic              x_v_o,
  output logic [DATA_W-1:0] x_d_o,
  input  logic              w_v_i,
  input  logic              w_f_i,
  input  logic [DATA_W-1:0] w_d_i,
  output logic              w_v_o,
  output logic              w_f_o,
  output logic [DATA_W-1:0] w_d_o,
  output logic              emit_o,
  output logic [ACC_W-1:0]  res_o
);

  localparam int unsigned CNT_W  = $clog2(NUM_TAPS + 1);
  localparam int unsigned PROD_W = 2 * DATA_W;

  logic              x_v_q, w_v_q, w_f_q, live_q;
  logic [DATA_W-1:0] x_d_q, w_d_q;
  logic signed [ACC_W-1:0] acc_q, acc_n, prod_ext;
  logic signed [PROD_W-1:0] prod;
  logic [CNT_W-1:0]  cnt_q, cnt_n;
  cell_act_e         act;
  logic              emit;

  // operand pipelines: samples move right, coefficients move left
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      x_v_q <= 1'b0;
      x_d_q <= '0;
      w_v_q <= 1'b0;
      w_f_q <= 1'b0;
      w_d_q <= '0;
    end else begin
      x_v_q <= x_v_i;
      x_d_q <= x_d_i;
      w_v_q <= w_v_i;
      w_f_q <= w_f_i & w_v_i;
      w_d_q <= w_d_i;
    end
  end

  always_comb begin
    prod     = $signed(x_d_q) * $signed(w_d_q);
    prod_ext = ACC_W'(prod);
    if (x_v_q && w_v_q && w_f_q)      act = CELL_START;
    else if (x_v_q && w_v_q && live_q) act = CELL_ADD;
    else if (x_v_q || w_v_q)           act = CELL_DROP;  // unmatched slot breaks the window
    else                               act = CELL_IDLE;
    acc_n = (act == CELL_START) ? prod_ext : acc_q + prod_ext;
    cnt_n = (act == CELL_START) ? CNT_W'(1) : cnt_q + CNT_W'(1);
    emit  = ((act == CELL_START) || (act == CELL_ADD)) && (cnt_n == CNT_W'(NUM_TAPS));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q  <= '0;
      cnt_q  <= '0;
      live_q <= 1'b0;
    end else begin
      unique case (act)
        CELL_START, CELL_ADD: begin
          if (emit) begin
            acc_q  <= '0;
            cnt_q  <= '0;
            live_q <= 1'b0;
          end else begin
            acc_q  <= acc_n;
            cnt_q  <= cnt_n;
            live_q <= 1'b1;
          end
        end
        CELL_DROP: begin
          acc_q  <= '0;
          cnt_q  <= '0;
          live_q <= 1'b0;
        end
        default: ;
      endcase
    end
  end

  assign x_v_o  = x_v_q;
  assign x_d_o  = x_d_q;
  assign w_v_o  = w_v_q;
  assign w_f_o  = w_f_q;
  assign w_d_o  = w_d_q;
  assign emit_o = emit;
  assign res_o  = acc_n;

  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(NUM_TAPS)); // R7

  AST_ACC_NEEDS_PAIR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(x_v_q && w_v_q) |=> (acc_q == $past(acc_q)) || (acc_q == '0)); // R3

endmodule

// File: rtl/cfc_drain.sv
module cfc_drain #(
  parameter int unsigned ACC_W = 18
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [ACC_W-1:0] load_d_i,
  input  logic             prev_v_i,
  input  logic [ACC_W-1:0] prev_d_i,
  output logic             v_o,
  output logic [ACC_W-1:0] d_o
);

  logic             v_q;
  logic [ACC_W-1:0] d_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v_q <= 1'b0;
      d_q <= '0;
    end else begin
      v_q <= load_i | prev_v_i;
      d_q <= load_i ? load_d_i : prev_d_i;
    end
  end

  assign v_o = v_q;
  assign d_o = d_q;

  AST_DRAIN_NO_CLASH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |-> !prev_v_i); // R6

endmodule

// File: rtl/cf_convolver.sv
module cf_convolver
  import cfc_pkg::*;
#(
  parameter int unsigned NUM_TAPS = 4,
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned ACC_W    = acc_width(DATA_W, NUM_TAPS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              x_valid_i,
  input  logic [DATA_W-1:0] x_data_i,
  input  logic              w_valid_i,
  input  logic              w_first_i,
  input  logic [DATA_W-1:0] w_data_i,
  output logic              y_valid_o,
  output logic [ACC_W-1:0]  y_data_o
);

  localparam int unsigned LINKS = NUM_TAPS + 1;

  logic              x_v [LINKS];
  logic [DATA_W-1:0] x_d [LINKS];
  logic              w_v [LINKS];
  logic              w_f [LINKS];
  logic [DATA_W-1:0] w_d [LINKS];
  logic              dr_v [LINKS];
  logic [ACC_W-1:0]  dr_d [LINKS];

  assign x_v[0]        = x_valid_i;
  assign x_d[0]        = x_data_i;
  assign w_v[NUM_TAPS] = w_valid_i;
  assign w_f[NUM_TAPS] = w_first_i;
  assign w_d[NUM_TAPS] = w_data_i;
  assign dr_v[0]       = 1'b0;
  assign dr_d[0]       = '0;

  for (genvar c = 0; c < NUM_TAPS; c++) begin : g_cell
    logic             emit;
    logic [ACC_W-1:0] res;

    cfc_cell #(
      .NUM_TAPS(NUM_TAPS),
      .DATA_W  (DATA_W),
      .ACC_W   (ACC_W)
    ) i_cell (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .x_v_i (x_v[c]),
      .x_d_i (x_d[c]),
      .x_v_o (x_v[c+1]),
      .x_d_o (x_d[c+1]),
      .w_v_i (w_v[c+1]),
      .w_f_i (w_f[c+1]),
      .w_d_i (w_d[c+1]),
      .w_v_o (w_v[c]),
      .w_f_o (w_f[c]),
      .w_d_o (w_d[c]),
      .emit_o(emit),
      .res_o (res)
    );

    // drain runs with the samples; the opposite direction would collide
    cfc_drain #(
      .ACC_W(ACC_W)
    ) i_drain (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .load_i  (emit),
      .load_d_i(res),
      .prev_v_i(dr_v[c]),
      .prev_d_i(dr_d[c]),
      .v_o     (dr_v[c+1]),
      .d_o     (dr_d[c+1])
    );
  end

  assign y_valid_o = dr_v[NUM_TAPS];
  assign y_data_o  = dr_d[NUM_TAPS];

  AST_X_CADENCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    x_valid_i |=> !x_valid_i); // R2

  AST_W_CADENCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    w_valid_i |=> !w_valid_i); // R2

  AST_FIRST_WITH_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    w_first_i |-> w_valid_i); // R2

  AST_Y_SPACED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    y_valid_o |=> !y_valid_o); // R6

endmodule

// File: tb/test_cf_convolver.sv
`timescale 1ns/1ps
module test_cf_convolver;
  localparam int K  = 4;
  localparam int DW = 8;
  localparam int AW = 2 * DW + $clog2(K);
  localparam int WATCHDOG = 150000;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          x_valid, w_valid, w_first, y_valid;
  logic [DW-1:0] x_data, w_data;
  logic [AW-1:0] y_data;

  always #10 clk = ~clk;

  cf_convolver #(.NUM_TAPS(K), .DATA_W(DW)) i_cf_convolver (
    .clk_i    (clk),
    .rst_ni   (rst_n),
    .x_valid_i(x_valid),
    .x_data_i (x_data),
    .w_valid_i(w_valid),
    .w_first_i(w_first),
    .w_data_i (w_data),
    .y_valid_o(y_valid),
    .y_data_o (y_data)
  );

  int n_tests = 0;
  int n_fail  = 0;
  logic signed [DW-1:0] wt [K];
  logic signed [DW-1:0] xs [64];
  bit                   xv [64];
  longint               exp_q [$];

  task automatic check(bit ok, string req, longint act, longint expv);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0d exp=%0d", req, act, expv);
    end
  endtask

  function automatic longint ref_y(int s);
    longint acc = 0;
    for (int k = 0; k < K; k++) acc += longint'(wt[k]) * longint'(xs[s + k]);
    return acc;
  endfunction

  task automatic do_reset();
    rst_n = 1'b0;
    x_valid = 0; x_data = '0; w_valid = 0; w_first = 0; w_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // slot s at n=2s, coefficient position m at n=K-1+2m
  task automatic run_stream(int s_len, bit want_spacing, string tag);
    int nexp = 0, got = 0, last = -1;
    bit sp_ok = 1;
    do_reset();
    exp_q.delete();
    for (int s = 0; s + K <= s_len; s++) begin
      bit full = 1;
      for (int k = 0; k < K; k++) if (!xv[s + k]) full = 0;
      if (full) begin exp_q.push_back(ref_y(s)); nexp++; end
    end
    for (int n = 0; n < 2 * s_len + 4 * K + 16; n++) begin
      if (y_valid) begin
        longint act = longint'($signed(y_data));
        got++;
        if (exp_q.size() == 0) check(0, {"R5 spurious result ", tag}, act, 0);
        else begin
          longint e = exp_q.pop_front();
          check(act == e, {"R3 R4 value/order ", tag}, act, e);
        end
        if (last >= 0 && n - last != 2) sp_ok = 0;
        last = n;
      end
      if (n % 2 == 0 && n / 2 < s_len && xv[n / 2]) begin
        x_valid = 1; x_data = xs[n / 2];
      end else begin
        x_valid = 0; x_data = '0;
      end
      if (n >= K - 1 && (n - (K - 1)) % 2 == 0) begin
        int m = (n - (K - 1)) / 2;
        w_valid = 1; w_data = wt[m % K]; w_first = (m % K == 0);
      end else begin
        w_valid = 0; w_data = '0; w_first = 0;
      end
      @(negedge clk);
    end
    check(got == nexp, {"R5 result count ", tag}, got, nexp);
    if (want_spacing) check(sp_ok, {"R6 two-cycle exit ", tag}, sp_ok, 1);
  endtask

  initial begin
    #(longint'(WATCHDOG) * 20);
    n_tests++; n_fail++;
    $display("FAIL watchdog act=hung exp=finished");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    rst_n = 1'b0;
    x_valid = 0; x_data = '0; w_valid = 0; w_first = 0; w_data = '0;
    repeat (2) @(negedge clk);
    check(y_valid == 0, "R1 valid low in reset", y_valid, 0);
    do_reset();
    check(y_valid == 0, "R1 valid low after reset", y_valid, 0);

    // continuous random stream
    for (int k = 0; k < K; k++) wt[k] = DW'($urandom_range(0, 255));
    for (int s = 0; s < 64; s++) begin xs[s] = DW'($urandom_range(0, 255)); xv[s] = 1; end
    run_stream(30, 1, "continuous");

    // random empty slots
    for (int k = 0; k < K; k++) wt[k] = DW'($urandom_range(0, 255));
    for (int s = 0; s < 64; s++) begin
      xs[s] = DW'($urandom_range(0, 255));
      xv[s] = ($urandom_range(0, 3) != 0);
    end
    xv[7] = 0;
    run_stream(40, 0, "gaps");

    // impulse reveals coefficient order
    wt[0] = 3; wt[1] = -5; wt[2] = 7; wt[3] = 11;
    for (int s = 0; s < 64; s++) begin xs[s] = 0; xv[s] = 1; end
    xs[5] = 1;
    run_stream(12, 1, "impulse");

    // extremes: R8 full precision
    for (int k = 0; k < K; k++) wt[k] = -128;
    for (int s = 0; s < 64; s++) begin xs[s] = -128; xv[s] = 1; end
    run_stream(K + 2, 1, "R8 min*min");
    for (int k = 0; k < K; k++) wt[k] = (k % 2 == 0) ? -128 : 127;
    for (int s = 0; s < 64; s++) xs[s] = (s % 2 == 0) ? 127 : -128;
    run_stream(K + 3, 1, "R8 mixed");

    // boundary lengths
    for (int k = 0; k < K; k++) wt[k] = DW'($urandom_range(0, 255));
    for (int s = 0; s < 64; s++) xs[s] = DW'($urandom_range(0, 255));
    run_stream(K, 0, "R5 exactly K");
    run_stream(K - 1, 0, "R5 K-1");

    do_reset();
    check(y_valid == 0, "R1 idle after final reset", y_valid, 0);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule